// File: doc/BRIEF.md
# Standby power mode controller

This controller decides when a processor core drops into its deepest low-power state and which events bring it back. The core asks for standby by pulsing a wait-for-interrupt or wait-for-event strobe, or by returning from an interrupt handler while its sleep-on-exit option is set. The request is honoured only if deep-sleep and the power-down selector are both set, nothing relevant is pending, and no armed wakeup flag is already raised. A refused request is dropped, and the controller stays in the run state.

While in standby, any of the following wakes the core: a rising edge on the external wake pin, an armed real-time-clock flag, a low level on the external reset pin, or a watchdog reset. A wake is never an instant resume. The controller drives a domain reset pulse of fixed length, sets a sticky standby flag that the domain reset leaves alone, and only then leaves the standby state. Software clears the flag by writing one to it. A power-on reset also clears it.

Top module: `standby_ctrl`

## Requirements
- R1: After power-on reset (`porN` low), `standbyActive`, `domainResetPulse` and `standbyFlag` are all 0.
- R2: A wait-for-interrupt strobe sampled in run state, with deep-sleep and power-down-select both 1, no interrupt pending and no wakeup or armed clock flag set, raises `standbyActive` on the next clock edge.
- R3: A wait-for-interrupt request is refused while `irqPending` is 1. A wait-for-event request is refused while `evtPending` is 1. A wait-for-event request ignores `irqPending`.
- R4: No entry path succeeds while `deepSleepEn` or `pwrDownSel` is 0.
- R5: Entry is refused while `wakeFlag` is 1, or while any bit of `rtcFlags & rtcSrcMask` is 1. A raised clock flag whose mask bit is 0 does not block entry. Bit order of both vectors: 0 alarm A, 1 alarm B, 2 periodic wakeup, 3 tamper, 4 timestamp.
- R6: A return-from-interrupt strobe enters standby only when `sleepOnExitEn` is 1, deep-sleep and power-down-select are 1, no interrupt is pending, and the wakeup and armed clock flags are clear.
- R7: In standby, a rising edge on `wakePin` causes exit. The pin passes through two synchroniser flops and an edge detector, so the exit begins on the third clock edge after the pin rises. A pin that was already high at entry does not cause exit.
- R8: In standby, an armed clock flag, `extResetN` at 0, or `wdgReset` at 1 causes exit on the next edge. In run state these inputs change no output.
- R9: On exit, `domainResetPulse` is 1 for exactly 16 cycles. `standbyActive` stays 1 throughout those cycles and falls together with the pulse.
- R10: `standbyFlag` becomes 1 on the edge where exit starts and holds until a `statusClr` strobe or a power-on reset clears it.
- R11: A refused request is discarded. If the blocking condition clears later without a new strobe, the controller stays in run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| wfiStrobe | input | 1 | Wait-for-interrupt request pulse |
| wfeStrobe | input | 1 | Wait-for-event request pulse |
| isrReturnStrobe | input | 1 | Return-from-interrupt pulse |
| deepSleepEn | input | 1 | Core deep-sleep enable |
| sleepOnExitEn | input | 1 | Core sleep-on-exit enable |
| pwrDownSel | input | 1 | Selects standby rather than a lighter sleep |
| irqPending | input | 1 | An interrupt is pending |
| evtPending | input | 1 | An event is pending |
| wakeFlag | input | 1 | Wakeup flag from the status register |
| rtcFlags | input | 5 | Clock flags: alarm A, alarm B, periodic, tamper, timestamp |
| rtcSrcMask | input | 5 | Selects which clock flags are armed wakeup sources |
| wakePin | input | 1 | Asynchronous external wake pin |
| extResetN | input | 1 | External reset pin, active low |
| wdgReset | input | 1 | Watchdog reset request |
| statusClr | input | 1 | Write-one-to-clear strobe for the standby flag |
| standbyActive | output | 1 | Core is in standby or in the exit reset |
| domainResetPulse | output | 1 | Reset for the powered-down domain during exit |
| standbyFlag | output | 1 | Sticky flag showing that standby was left |

## Verification
Each entry path is driven with its own enable turned on, and then with one condition at a time turned off. This shows that every gate (pending interrupt or event, deep-sleep, power-down select, wakeup flag, armed against unarmed clock flag, sleep-on-exit) blocks entry by itself. The four wake sources are used in separate standby sessions, so an exit can be traced to the source that caused it. The wake pin is held high across entry to show that a level does not wake the core, while a later rising edge does. Refused requests are followed by cycles in which the blocking input clears, which tells a discarded request apart from one that was kept. A per-cycle behavioural model compares all three outputs, including the 16-cycle pulse length and the way the flag persists and is cleared.

// File: rtl/standby_pkg.sv
package standby_pkg;
  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_STBY = 2'd1,
    PS_EXIT = 2'd2
  } pwrState_t;

  typedef struct packed {
    logic setFlag;
    logic loadCnt;
    logic runCnt;
  } ctlStrobe_t;
endpackage

// File: rtl/standby_ctl.sv
module standby_ctl
  import standby_pkg::*;
#(
  parameter int RTC_W = 5
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             wfiStrobe,
  input  logic             wfeStrobe,
  input  logic             isrReturnStrobe,
  input  logic             deepSleepEn,
  input  logic             sleepOnExitEn,
  input  logic             pwrDownSel,
  input  logic             irqPending,
  input  logic             evtPending,
  input  logic             wakeFlag,
  input  logic [RTC_W-1:0] rtcFlags,
  input  logic [RTC_W-1:0] rtcSrcMask,
  input  logic             pinRise,
  input  logic             extResetN,
  input  logic             wdgReset,
  input  logic             cntDone,
  output ctlStrobe_t       strobe,
  output pwrState_t        state
);
  pwrState_t nextState;
  logic rtcArmed, gateOk, reqOk, wakeAny;

  always_comb begin
    rtcArmed = |(rtcFlags & rtcSrcMask);
    gateOk   = deepSleepEn & pwrDownSel & ~wakeFlag & ~rtcArmed;
    reqOk    = gateOk & ((wfiStrobe & ~irqPending) |
                         (wfeStrobe & ~evtPending) |
                         (isrReturnStrobe & sleepOnExitEn & ~irqPending));
    wakeAny  = pinRise | rtcArmed | ~extResetN | wdgReset;
  end

  always_comb begin
    nextState      = state;
    strobe         = '0;
    unique case (state)
      PS_RUN:  if (reqOk) nextState = PS_STBY;
      PS_STBY: if (wakeAny) begin
                 nextState      = PS_EXIT;
                 strobe.setFlag = 1'b1;
                 strobe.loadCnt = 1'b1;
               end
      PS_EXIT: begin
                 strobe.runCnt = 1'b1;
                 if (cntDone) nextState = PS_RUN;
               end
      default: nextState = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= PS_RUN;
    else       state <= nextState;
  end

  // R4: no entry without deep-sleep and power-down select
  p_entry_gated_r4: assert property (@(posedge clk) disable iff (!porN)
    (state == PS_RUN && !(deepSleepEn && pwrDownSel)) |=> state == PS_RUN);

  // R5: wakeup flag blocks entry
  p_wakeflag_blocks_r5: assert property (@(posedge clk) disable iff (!porN)
    (state == PS_RUN && wakeFlag) |=> state == PS_RUN);

  // R8: standby is held until some wake source appears
  p_stby_holds_r8: assert property (@(posedge clk) disable iff (!porN)
    (state == PS_STBY && !pinRise && extResetN && !wdgReset &&
     (rtcFlags & rtcSrcMask) == '0) |=> state == PS_STBY);

  // R9: exit reset is not cut short before the counter finishes
  p_exit_until_done_r9: assert property (@(posedge clk) disable iff (!porN)
    (state == PS_EXIT && !cntDone) |=> state == PS_EXIT);
endmodule

// File: rtl/standby_dp.sv
module standby_dp
  import standby_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYCLES  = 16
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       wakePin,
  input  logic       statusClr,
  input  ctlStrobe_t strobe,
  output logic       pinRise,
  output logic       cntDone,
  output logic       standbyFlag
);
  localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinPrev;
  logic [CNT_W-1:0]       cnt;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge porN)
        if (!porN) syncQ[0] <= 1'b0;
        else       syncQ[0] <= wakePin;
    end else begin : g_next
      always_ff @(posedge clk or negedge porN)
        if (!porN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= syncQ[g-1];
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) pinPrev <= 1'b0;
    else       pinPrev <= syncQ[SYNC_STAGES-1];
  end

  assign pinRise = syncQ[SYNC_STAGES-1] & ~pinPrev;
  assign cntDone = (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                        cnt <= '0;
    else if (strobe.loadCnt)          cnt <= '0;
    else if (strobe.runCnt && !cntDone) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)               standbyFlag <= 1'b0;
    else if (strobe.setFlag) standbyFlag <= 1'b1;
    else if (statusClr)      standbyFlag <= 1'b0;
  end

  // R10: exit always leaves the flag set
  p_flag_set_r10: assert property (@(posedge clk) disable iff (!porN)
    strobe.setFlag |=> standbyFlag);

  // R10: flag only changes through set or clear
  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!porN)
    (!strobe.setFlag && !statusClr) |=> $stable(standbyFlag));
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import standby_pkg::*;
#(
  parameter int RTC_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYCLES  = 16
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             wfiStrobe,
  input  logic             wfeStrobe,
  input  logic             isrReturnStrobe,
  input  logic             deepSleepEn,
  input  logic             sleepOnExitEn,
  input  logic             pwrDownSel,
  input  logic             irqPending,
  input  logic             evtPending,
  input  logic             wakeFlag,
  input  logic [RTC_W-1:0] rtcFlags,
  input  logic [RTC_W-1:0] rtcSrcMask,
  input  logic             wakePin,
  input  logic             extResetN,
  input  logic             wdgReset,
  input  logic             statusClr,
  output logic             standbyActive,
  output logic             domainResetPulse,
  output logic             standbyFlag
);
  ctlStrobe_t strobe;
  pwrState_t  state;
  logic       pinRise, cntDone;

  standby_ctl #(.RTC_W(RTC_W)) u_ctl (
    .clk(clk), .porN(porN),
    .wfiStrobe(wfiStrobe), .wfeStrobe(wfeStrobe),
    .isrReturnStrobe(isrReturnStrobe),
    .deepSleepEn(deepSleepEn), .sleepOnExitEn(sleepOnExitEn),
    .pwrDownSel(pwrDownSel), .irqPending(irqPending),
    .evtPending(evtPending), .wakeFlag(wakeFlag),
    .rtcFlags(rtcFlags), .rtcSrcMask(rtcSrcMask),
    .pinRise(pinRise), .extResetN(extResetN), .wdgReset(wdgReset),
    .cntDone(cntDone), .strobe(strobe), .state(state)
  );

  standby_dp #(.SYNC_STAGES(SYNC_STAGES), .RST_CYCLES(RST_CYCLES)) u_dp (
    .clk(clk), .porN(porN), .wakePin(wakePin), .statusClr(statusClr),
    .strobe(strobe), .pinRise(pinRise), .cntDone(cntDone),
    .standbyFlag(standbyFlag)
  );

  assign standbyActive    = (state != PS_RUN);
  assign domainResetPulse = (state == PS_EXIT);

  // R2: entry shows as standbyActive without a reset pulse
  p_entry_clean_r2: assert property (@(posedge clk) disable iff (!porN)
    $rose(standbyActive) |-> !domainResetPulse);

  // R9: pulse end and standby end coincide
  p_pulse_end_r9: assert property (@(posedge clk) disable iff (!porN)
    $fell(domainResetPulse) |-> !standbyActive);
endmodule

// File: tb/sim_standby_ctrl.sv
module sim_standby_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE_LEN  = 16;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic wfiStrobe = 0, wfeStrobe = 0, isrReturnStrobe = 0;
  logic deepSleepEn = 0, sleepOnExitEn = 0, pwrDownSel = 0;
  logic irqPending = 0, evtPending = 0, wakeFlag = 0;
  logic [4:0] rtcFlags = '0, rtcSrcMask = '0;
  logic wakePin = 0, extResetN = 1, wdgReset = 0, statusClr = 0;
  logic standbyActive, domainResetPulse, standbyFlag;

  int checks = 0, fails = 0, cycles = 0;
  string curReq = "R1";

  // reference model state
  int  mMode = 0;        // 0 run, 1 standby, 2 exit
  int  mLeft = 0;        // exit cycles remaining
  bit  mFlag = 0;
  bit  pinHist[$];       // pin samples, newest first

  always #(CLK_PERIOD/2) clk = ~clk;

  standby_ctrl u0 (
    .clk(clk), .porN(porN), .wfiStrobe(wfiStrobe), .wfeStrobe(wfeStrobe),
    .isrReturnStrobe(isrReturnStrobe), .deepSleepEn(deepSleepEn),
    .sleepOnExitEn(sleepOnExitEn), .pwrDownSel(pwrDownSel),
    .irqPending(irqPending), .evtPending(evtPending), .wakeFlag(wakeFlag),
    .rtcFlags(rtcFlags), .rtcSrcMask(rtcSrcMask), .wakePin(wakePin),
    .extResetN(extResetN), .wdgReset(wdgReset), .statusClr(statusClr),
    .standbyActive(standbyActive), .domainResetPulse(domainResetPulse),
    .standbyFlag(standbyFlag)
  );

  always @(posedge clk or negedge porN) begin
    if (!porN) begin
      mMode = 0; mLeft = 0; mFlag = 0;
      pinHist = '{0, 0, 0};
    end else begin
      bit armed, ok, rise, wake;
      armed = (rtcFlags & rtcSrcMask) != 0;
      rise  = pinHist[1] && !pinHist[2];
      ok = deepSleepEn && pwrDownSel && !wakeFlag && !armed &&
           ((wfiStrobe && !irqPending) || (wfeStrobe && !evtPending) ||
            (isrReturnStrobe && sleepOnExitEn && !irqPending));
      wake = rise || armed || !extResetN || wdgReset;
      if (mMode == 0) begin
        if (ok) mMode = 1;
      end else if (mMode == 1) begin
        if (wake) begin mMode = 2; mLeft = PULSE_LEN; mFlag = 1; end
      end else begin
        mLeft--;
        if (mLeft == 0) mMode = 0;
      end
      if (!(mMode == 2 && mLeft == PULSE_LEN) && statusClr) mFlag = 0;
      pinHist.push_front(wakePin);
      void'(pinHist.pop_back());
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    check(curReq, "standbyActive", standbyActive, mMode != 0);
    check(curReq, "domainResetPulse", domainResetPulse, mMode == 2);
    check(curReq, "standbyFlag", standbyFlag, mFlag);
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wfi();
    wfiStrobe = 1; cyc(1); wfiStrobe = 0; cyc(1);
  endtask
  task automatic wfe();
    wfeStrobe = 1; cyc(1); wfeStrobe = 0; cyc(1);
  endtask
  task automatic isrRet();
    isrReturnStrobe = 1; cyc(1); isrReturnStrobe = 0; cyc(1);
  endtask
  task automatic wdgWake();
    wdgReset = 1; cyc(1); wdgReset = 0; cyc(PULSE_LEN + 2);
  endtask

  initial begin
    cyc(3);
    curReq = "R1";
    check("R1", "active after por", standbyActive, 0);
    check("R1", "pulse after por", domainResetPulse, 0);
    check("R1", "flag after por", standbyFlag, 0);
    porN = 1; cyc(2);

    curReq = "R4";
    pwrDownSel = 1; wfi();
    check("R4", "no entry without deep-sleep", standbyActive, 0);
    deepSleepEn = 1; pwrDownSel = 0; wfi(); wfe();
    check("R4", "no entry without power-down select", standbyActive, 0);
    pwrDownSel = 1;

    curReq = "R3";
    irqPending = 1; wfi();
    check("R3", "wfi refused with irq pending", standbyActive, 0);
    evtPending = 1; wfe();
    check("R3", "wfe refused with event pending", standbyActive, 0);
    evtPending = 0;
    wfeStrobe = 1; cyc(1); wfeStrobe = 0;
    check("R3", "wfe enters despite irq", standbyActive, 1);
    irqPending = 0; cyc(3);
    curReq = "R8";
    wdgWake();
    check("R8", "watchdog wake back to run", standbyActive, 0);
    check("R10", "flag set after exit", standbyFlag, 1);
    cyc(5);
    check("R10", "flag persists", standbyFlag, 1);
    curReq = "R10";
    statusClr = 1; cyc(1); statusClr = 0;
    check("R10", "flag cleared by write", standbyFlag, 0);

    curReq = "R5";
    wakeFlag = 1; wfi();
    check("R5", "wakeFlag blocks", standbyActive, 0);
    wakeFlag = 0; rtcSrcMask = 5'b00001; rtcFlags = 5'b00001; wfi();
    check("R5", "armed alarm A blocks", standbyActive, 0);
    rtcSrcMask = 5'b10000; rtcFlags = 5'b10000; wfi();
    check("R5", "armed timestamp blocks", standbyActive, 0);
    rtcFlags = 5'b00010; rtcSrcMask = 5'b00001;
    wfiStrobe = 1; cyc(1); wfiStrobe = 0;
    check("R2", "wfi entry", standbyActive, 1);
    check("R5", "unarmed flag does not block", standbyActive, 1);
    cyc(4);
    curReq = "R8";
    rtcFlags = 5'b00011; cyc(1); rtcFlags = 5'b0;
    check("R8", "armed clock flag wakes", domainResetPulse, 1);
    cyc(PULSE_LEN + 2);
    rtcSrcMask = '0;

    curReq = "R11";
    irqPending = 1; wfi(); irqPending = 0; cyc(6);
    check("R11", "refused request discarded", standbyActive, 0);

    curReq = "R6";
    isrRet();
    check("R6", "no entry without sleep-on-exit", standbyActive, 0);
    sleepOnExitEn = 1; irqPending = 1; isrRet();
    check("R6", "no entry with irq pending", standbyActive, 0);
    irqPending = 0; wakeFlag = 1; isrRet();
    check("R6", "no entry with wakeFlag", standbyActive, 0);
    wakeFlag = 0;
    isrReturnStrobe = 1; cyc(1); isrReturnStrobe = 0;
    check("R6", "isr return enters", standbyActive, 1);
    sleepOnExitEn = 0; cyc(3);
    curReq = "R8";
    extResetN = 0; cyc(1);
    check("R8", "external reset wakes", domainResetPulse, 1);
    cyc(1); extResetN = 1; cyc(PULSE_LEN + 2);

    curReq = "R7";
    statusClr = 1; cyc(1); statusClr = 0;
    wakePin = 1; cyc(5); wfi(); cyc(10);
    check("R7", "pin high at entry no wake", standbyActive, 1);
    check("R7", "pin high at entry no pulse", domainResetPulse, 0);
    wakePin = 0; cyc(5);
    wakePin = 1; cyc(2);
    check("R7", "no exit before third edge", domainResetPulse, 0);
    cyc(1);
    check("R7", "exit on third edge after rise", domainResetPulse, 1);
    curReq = "R9";
    begin
      int n = 1;
      int activeLow = 0;
      for (int i = 0; i < 30; i++) begin
        cyc(1);
        if (domainResetPulse) n++;
        if (domainResetPulse && !standbyActive) activeLow++;
      end
      check("R9", "pulse length", n, PULSE_LEN);
      check("R9", "active during pulse", activeLow, 0);
    end
    check("R9", "active falls with pulse", standbyActive, 0);
    wakePin = 0;

    curReq = "R8";
    wdgReset = 1; extResetN = 0; rtcSrcMask = 5'b11111; rtcFlags = 5'b11111;
    cyc(3);
    check("R8", "run state ignores wake sources", standbyActive, 0);
    check("R8", "no pulse in run", domainResetPulse, 0);
    check("R8", "flag untouched in run", standbyFlag, 1);
    wdgReset = 0; extResetN = 1; rtcFlags = '0; rtcSrcMask = '0; cyc(2);

    curReq = "R1";
    porN = 0; cyc(2);
    check("R1", "por clears flag", standbyFlag, 0);
    porN = 1; cyc(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule